// File: doc/BRIEF.md
# Operand barrel shifter with carry-out

A combinational shifter that conditions a 32-bit operand before it reaches an ALU input. A 3-bit type code selects how the operand moves. The choices are a logical shift toward the high end, a logical shift toward the low end, an arithmetic shift toward the low end, a rotation toward the low end, and a one-position rotation that goes through the carry flag. The distance is a 5-bit amount from 0 to 31.

Next to the shifted word, the block returns a carry that a flag unit can latch. For a non-zero distance, this carry is the last bit that left the word. For a zero distance, the incoming carry passes through unchanged.

Internally, left shifts reuse the right-shift datapath by mirroring the operand and then the result. A chain of logarithmic stages handles every distance.

Top module: `bshift_top`

## Requirements
- R1: Code 3'b000 shifts toward the high end by n and fills the n low bits with zeros; bits past bit 31 are lost.
- R2: Code 3'b001 shifts toward the low end by n and fills the n high bits with zeros.
- R3: Code 3'b010 shifts toward the low end by n and fills the n high bits with copies of the original bit 31.
- R4: Code 3'b011 rotates toward the low end by n; bits leaving bit 0 re-enter at bit 31.
- R5: Code 3'b100 ignores the amount. The result is {carry_i, operand[31:1]} and carry_o is operand[0].
- R6: For codes 3'b000 to 3'b011 with n greater than 0, carry_o is the last bit shifted out. That is operand bit 32-n for code 3'b000, and operand bit n-1 for codes 3'b001, 3'b010 and 3'b011.
- R7: For codes 3'b000 to 3'b011 with n equal to 0, the result equals the operand and carry_o equals carry_i.
- R8: Codes 3'b101, 3'b110 and 3'b111 return the operand unchanged, with carry_o equal to carry_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Word to shift |
| op_i | input | 3 | Shift type code |
| amount_i | input | 5 | Shift distance 0..31 |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The corner that is hardest to reach is a carry taken from the extreme bit positions. These are a left shift by 1 (carry from bit 31), a left or right shift by 31 (bit 1 or bit 30), and the zero-distance case, where the carry must come from the flag input rather than the operand. The stimulus pins each of these with operands that hold a single 1 or a single 0 at the targeted bit. It drives the incoming carry to the opposite value, so a carry taken from the wrong source cannot match by chance. Arithmetic shifts use operands of both signs, and rotation uses asymmetric patterns so that a wrong direction shows.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [2:0] {
    SH_LSL = 3'b000,
    SH_LSR = 3'b001,
    SH_ASR = 3'b010,
    SH_ROR = 3'b011,
    SH_RRX = 3'b100
  } shift_op_e;
endpackage

// File: rtl/bshift_stage.sv
// One log stage: moves data toward bit 0 by DIST when en_i is set.
module bshift_stage #(
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  logic [W-1:0] data_i,
  input  logic         en_i,
  input  logic         rot_i,
  input  logic         fill_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] moved;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i + DIST < W) begin : g_in
      assign moved[i] = data_i[i+DIST];
    end else begin : g_wrap
      assign moved[i] = rot_i ? data_i[i+DIST-W] : fill_i;
    end
  end

  assign data_o = en_i ? moved : data_i;
endmodule

// File: rtl/bshift_carry.sv
// Picks the last bit shifted out of the (possibly mirrored) core input.
module bshift_carry #(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  core_i,
  input  logic [AW-1:0] amount_i,
  input  logic          carry_i,
  output logic          carry_o
);
  logic [AW-1:0] idx;

  assign idx     = amount_i - AW'(1);
  assign carry_o = (amount_i == '0) ? carry_i : core_i[idx];
endmodule

// File: rtl/bshift_top.sv
module bshift_top
  import bshift_pkg::*;
#(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  operand_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] amount_i,
  input  logic          carry_i,
  output logic [W-1:0]  result_o,
  output logic          carry_o
);
  logic          is_left, is_rot, fill_bit, std_op;
  logic [W-1:0]  core_in, core_out, shifted, mirrored_out;
  logic [W-1:0]  stage_d [AW+1];
  logic          std_carry;

  assign is_left  = (op_i == SH_LSL);
  assign is_rot   = (op_i == SH_ROR);
  assign fill_bit = (op_i == SH_ASR) & operand_i[W-1];
  assign std_op   = (op_i <= SH_ROR);

  // Left shifts run through the right-shift chain on a mirrored word.
  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign core_in[i]      = is_left ? operand_i[W-1-i] : operand_i[i];
    assign mirrored_out[i] = core_out[W-1-i];
  end

  assign stage_d[0] = core_in;
  for (genvar k = 0; k < AW; k++) begin : g_stage
    bshift_stage #(.W(W), .DIST(1 << k)) u_stage (
      .data_i (stage_d[k]),
      .en_i   (amount_i[k]),
      .rot_i  (is_rot),
      .fill_i (fill_bit),
      .data_o (stage_d[k+1])
    );
  end
  assign core_out = stage_d[AW];
  assign shifted  = is_left ? mirrored_out : core_out;

  bshift_carry #(.W(W)) u_carry (
    .core_i   (core_in),
    .amount_i (amount_i),
    .carry_i  (carry_i),
    .carry_o  (std_carry)
  );

  always_comb begin
    if (std_op) begin
      result_o = shifted;
      carry_o  = std_carry;
    end else if (op_i == SH_RRX) begin
      result_o = {carry_i, operand_i[W-1:1]};
      carry_o  = operand_i[0];
    end else begin
      result_o = operand_i;
      carry_o  = carry_i;
    end
  end

  logic [W-1:0] lo_mask, hi_mask;
  assign lo_mask = ~({W{1'b1}} << amount_i);
  assign hi_mask = ~({W{1'b1}} >> amount_i);

  always_comb begin
    if (op_i == SH_LSL)
      p_lsl_zero_fill_r1: assert ((result_o & lo_mask) == '0);
    if (op_i == SH_LSR)
      p_lsr_zero_fill_r2: assert ((result_o & hi_mask) == '0);
    if (op_i == SH_ASR)
      p_asr_sign_fill_r3: assert ((result_o & hi_mask) == (operand_i[W-1] ? hi_mask : '0));
    if (op_i == SH_ROR)
      p_ror_keeps_ones_r4: assert ($countones(result_o) == $countones(operand_i));
    if (op_i == SH_RRX)
      p_rrx_flag_in_r5: assert (result_o[W-1] == carry_i && carry_o == operand_i[0]);
    if (std_op && amount_i == '0)
      p_zero_amount_r7: assert (result_o == operand_i && carry_o == carry_i);
    if (op_i > SH_RRX)
      p_pass_through_r8: assert (result_o == operand_i && carry_o == carry_i);
  end
endmodule

// File: tb/tb_bshift_top.sv
module tb_bshift_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] operand;
  logic [2:0]  op;
  logic [4:0]  amount;
  logic        cin;
  logic [31:0] result;
  logic        cout;

  int tests_run = 0;
  int tests_failed = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        c;
    string       req;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bshift_top dut (
    .operand_i (operand),
    .op_i      (op),
    .amount_i  (amount),
    .carry_i   (cin),
    .result_o  (result),
    .carry_o   (cout)
  );

  function automatic exp_t model(logic [31:0] a, logic [2:0] o, int n, logic c, string req);
    exp_t e;
    logic [32:0] t;
    logic [63:0] d;
    e.req = req;
    case (o)
      3'b000: begin t = {c, a} << n; e.res = t[31:0]; e.c = t[32]; end
      3'b001: begin t = {a, c} >> n; e.res = t[32:1]; e.c = t[0]; end
      3'b010: begin t = 33'($signed({a, c}) >>> n); e.res = t[32:1]; e.c = t[0]; end
      3'b011: begin d = {a, a} >> n; e.res = d[31:0]; e.c = (n == 0) ? c : e.res[31]; end
      3'b100: begin e.res = {c, a[31:1]}; e.c = a[0]; end
      default: begin e.res = a; e.c = c; end
    endcase
    return e;
  endfunction

  task automatic send(logic [31:0] a, logic [2:0] o, int n, logic c, string req);
    @(posedge clk);
    #1;
    operand = a; op = o; amount = 5'(n); cin = c;
    q.push_back(model(a, o, n, c, req));
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      tests_run++;
      if (result !== e.res || cout !== e.c) begin
        tests_failed++;
        $display("FAIL %s: got res=%h c=%b, expected res=%h c=%b",
                 e.req, result, cout, e.res, e.c);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      tests_failed++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    operand = '0; op = '0; amount = '0; cin = 1'b0;
    // R1 / R6: left shifts, carry from bit 32-n
    send(32'h8000_0001, 3'b000, 1, 1'b0, "R1");
    send(32'h0000_0002, 3'b000, 31, 1'b0, "R6");
    send(32'hFFFF_FFFD, 3'b000, 31, 1'b1, "R6");
    send(32'h1234_5678, 3'b000, 4, 1'b1, "R1");
    // R2 / R6: logical right
    send(32'h8000_0001, 3'b001, 1, 1'b0, "R2");
    send(32'h4000_0000, 3'b001, 31, 1'b0, "R6");
    send(32'hF0F0_1234, 3'b001, 8, 1'b1, "R2");
    // R3: arithmetic right, both signs
    send(32'h8000_0000, 3'b010, 31, 1'b1, "R3");
    send(32'h8765_4321, 3'b010, 4, 1'b0, "R3");
    send(32'h7654_3210, 3'b010, 5, 1'b1, "R3");
    send(32'hC000_0000, 3'b010, 1, 1'b1, "R3");
    // R4: rotate
    send(32'h0000_0001, 3'b011, 1, 1'b0, "R4");
    send(32'h1234_5678, 3'b011, 12, 1'b0, "R4");
    send(32'hFFFF_FFFE, 3'b011, 31, 1'b1, "R6");
    // R5: rotate through carry, amount ignored
    send(32'h0000_0003, 3'b100, 0, 1'b0, "R5");
    send(32'h0000_0002, 3'b100, 17, 1'b1, "R5");
    // R7: zero amount
    send(32'hDEAD_BEEF, 3'b000, 0, 1'b0, "R7");
    send(32'hDEAD_BEEE, 3'b001, 0, 1'b1, "R7");
    send(32'h8000_0001, 3'b010, 0, 1'b0, "R7");
    send(32'h0000_0001, 3'b011, 0, 1'b0, "R7");
    // R8: unused codes
    send(32'hA5A5_5A5A, 3'b101, 3, 1'b1, "R8");
    send(32'h0000_0001, 3'b110, 9, 1'b0, "R8");
    send(32'hFFFF_FFFF, 3'b111, 31, 1'b0, "R8");
    // sweep all distances for the four standard codes
    for (int n = 0; n < 32; n++) begin
      for (int o = 0; o < 4; o++) begin
        send(32'h9E37_79B9 ^ (32'h1 << n), 3'(o), n, n[0], "R6");
      end
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule